// File: doc/BRIEF.md
# Page-Color Home Bank Mapper

This block chooses the home cache bank for a physical page in a tiled last-level cache. There are sixteen banks on a 4x4 grid, and each bank is paired with one core. A request carries a physical address, two class bits (whether the page is shared between cores, and whether it holds instructions or data), the number of the requesting core, and a placement scheme select. One clock edge later the block returns the index of the bank that should hold the page.

Private pages always stay in the requesting core's own bank. Shared pages follow the selected scheme:

- The central scheme puts all shared pages in the four banks at the middle of the grid.
- The replicate-code scheme puts shared data in the middle banks and places a copy of shared instructions in each requester's own bank.
- The spread scheme deals shared pages out over all sixteen banks.

The page number starts at address bit 12, because pages are 4 KB.

Top module: `pc_bank_mapper`

## Requirements
- R1: While `rst` is high at a rising clock edge, `home_valid` becomes 0 and `home_bank` becomes 0.
- R2: `home_valid` in each cycle equals the value `req_valid` had one rising edge earlier. `home_bank` is updated at the same edge as a request and has one cycle of latency.
- R3: A private request (`req_shared`=0) yields `home_bank` = `req_core`, for every scheme and for either value of `req_code`.
- R4: With `scheme_sel`=2'b00, every shared request maps to a central bank. Address bits [13:12] select the bank: 00 gives 5, 01 gives 6, 10 gives 9 and 11 gives 10.
- R5: With `scheme_sel`=2'b01, shared data (`req_code`=0) maps to a central bank exactly as in R4. Shared code (`req_code`=1) maps to bank `req_core`.
- R6: With `scheme_sel`=2'b10, a shared request maps to bank = address bits [15:12].
- R7: The spare encoding `scheme_sel`=2'b11 behaves exactly like 2'b10.
- R8: Address bits [11:0] and bits above 15 have no effect on `home_bank`.
- R9: In a cycle where `req_valid` is 0, `home_bank` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | ADDR_W (40) | Physical address of the page |
| req_shared | input | 1 | 1 = page shared between cores, 0 = private |
| req_code | input | 1 | 1 = instruction page, 0 = data page |
| req_core | input | 4 | Number of the requesting core |
| scheme_sel | input | 2 | Placement scheme: 00 central, 01 replicate code, 10 spread, 11 spread |
| home_valid | output | 1 | `home_bank` holds the answer to the previous cycle's request |
| home_bank | output | 4 | Index of the home bank |

## Verification
A wrong class decode or a wrong scheme decode shows up on `home_bank` at the edge right after the request that reaches the faulty path. For example, a shared page would land on the requester's bank, or a central-group page would land outside {5,6,9,10]. The sweep covers every combination of scheme, class, core and page nibble, and each request is checked one cycle later. Any such mapping fault is therefore seen within one cycle of the first request that triggers it. A register that loads without a request, or that drops its valid flag, is caught on the idle cycle that follows.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int GRID_DIM  = 4;
    localparam int NUM_BANKS = GRID_DIM * GRID_DIM;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int PAGE_LSB  = 12;
    localparam int CGRP_W    = 2;
    localparam int CGRP_BASE = GRID_DIM / 2 - 1;

    typedef enum logic [1:0] {
        SCH_CENTRAL   = 2'b00,
        SCH_REPL_CODE = 2'b01,
        SCH_SPREAD    = 2'b10,
        SCH_SPARE     = 2'b11
    } scheme_e;

    typedef enum logic [1:0] {
        HOME_LOCAL   = 2'd0,
        HOME_CENTRAL = 2'd1,
        HOME_SPREAD  = 2'd2
    } home_kind_e;

    typedef struct packed {
        logic shared;
        logic code;
    } page_class_t;

    typedef logic [BANK_W-1:0] bank_t;

    // Map a 2-bit central-group selector onto the middle 2x2 tiles of the grid.
    function automatic bank_t central_bank(input logic [CGRP_W-1:0] sel);
        int row;
        int col;
        row = CGRP_BASE + int'(sel[1]);
        col = CGRP_BASE + int'(sel[0]);
        return bank_t'(row * GRID_DIM + col);
    endfunction

    function automatic logic is_central(input bank_t b);
        int row;
        int col;
        row = int'(b) / GRID_DIM;
        col = int'(b) % GRID_DIM;
        return (row == CGRP_BASE || row == CGRP_BASE + 1) &&
               (col == CGRP_BASE || col == CGRP_BASE + 1);
    endfunction

endpackage

// File: rtl/page_classifier.sv
module page_classifier
    import bankmap_pkg::*;
(
    input  scheme_e     scheme,
    input  page_class_t cls,
    output home_kind_e  kind
);

    always_comb begin
        if (!cls.shared) begin
            kind = HOME_LOCAL;
        end else begin
            unique case (scheme)
                SCH_CENTRAL:   kind = HOME_CENTRAL;
                SCH_REPL_CODE: kind = cls.code ? HOME_LOCAL : HOME_CENTRAL;
                default:       kind = HOME_SPREAD;
            endcase
        end
    end

    // R3
    private_local_chk: assert final (cls.shared || kind == HOME_LOCAL);

endmodule

// File: rtl/bank_selector.sv
module bank_selector
    import bankmap_pkg::*;
(
    input  home_kind_e kind,
    input  bank_t      core,
    input  bank_t      page_bits,
    output bank_t      bank
);

    bank_t central_pick;

    assign central_pick = central_bank(page_bits[CGRP_W-1:0]);

    always_comb begin
        unique case (kind)
            HOME_LOCAL:   bank = core;
            HOME_CENTRAL: bank = central_pick;
            default:      bank = page_bits;
        endcase
    end

    // R4
    central_group_chk: assert final (kind != HOME_CENTRAL || is_central(bank));

endmodule

// File: rtl/pc_bank_mapper.sv
module pc_bank_mapper
    import bankmap_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_shared,
    input  logic              req_code,
    input  logic [BANK_W-1:0] req_core,
    input  logic [1:0]        scheme_sel,
    output logic              home_valid,
    output logic [BANK_W-1:0] home_bank
);

    localparam int PAGE_HI = PAGE_LSB + BANK_W;

    page_class_t cls;
    home_kind_e  kind;
    bank_t       page_bits;
    bank_t       next_bank;
    logic        addr_unused;

    assign cls.shared  = req_shared;
    assign cls.code    = req_code;
    assign page_bits   = req_addr[PAGE_LSB +: BANK_W];
    assign addr_unused = ^{req_addr[PAGE_LSB-1:0], req_addr[ADDR_W-1:PAGE_HI]};

    page_classifier u_classify (
        .scheme (scheme_e'(scheme_sel)),
        .cls    (cls),
        .kind   (kind)
    );

    bank_selector u_select (
        .kind      (kind),
        .core      (req_core),
        .page_bits (page_bits),
        .bank      (next_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            home_valid <= 1'b0;
            home_bank  <= '0;
        end else begin
            home_valid <= req_valid;
            if (req_valid) begin
                home_bank <= next_bank;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> home_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !home_valid);

    // R3
    private_home_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_shared) |=> (home_bank == $past(req_core)));

    // R5
    shared_data_central_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shared && !req_code && !scheme_sel[1]) |=> is_central(home_bank));

    // R6
    spread_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_shared && scheme_sel[1]) |=> (home_bank == $past(req_addr[PAGE_HI-1:PAGE_LSB])));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(home_bank));

endmodule

// File: tb/test_pc_bank_mapper.sv
module test_pc_bank_mapper;

    localparam int ADDR_W = 40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_shared = 1'b0;
    logic              req_code = 1'b0;
    logic [3:0]        req_core = '0;
    logic [1:0]        scheme_sel = '0;
    logic              home_valid;
    logic [3:0]        home_bank;

    int  errors = 0;
    int  checks = 0;
    int  cycles = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    pc_bank_mapper #(.ADDR_W(ADDR_W)) i_pc_bank_mapper (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_shared (req_shared),
        .req_code   (req_code),
        .req_core   (req_core),
        .scheme_sel (scheme_sel),
        .home_valid (home_valid),
        .home_bank  (home_bank)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic int model_bank(input int sch, input int sh, input int cd,
                                      input int core, input logic [ADDR_W-1:0] a);
        int pg;
        int ctr;
        pg  = int'(a[15:12]);
        ctr = 5 + (pg & 1) + 4 * ((pg >> 1) & 1);
        if (sh == 0) return core;
        case (sch)
            0:       return ctr;
            1:       return (cd != 0) ? core : ctr;
            default: return pg;
        endcase
    endfunction

    function automatic string tag_of(input int sch, input int sh);
        if (sh == 0) return "R3";
        case (sch)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic issue(input int sch, input int sh, input int cd, input int core,
                         input logic [ADDR_W-1:0] a);
        req_valid  = 1'b1;
        scheme_sel = 2'(sch);
        req_shared = 1'(sh);
        req_code   = 1'(cd);
        req_core   = 4'(core);
        req_addr   = a;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1'b1;
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        int k;
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(home_valid), 0);
        check("R1 bank", int'(home_bank), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle valid", int'(home_valid), 0);

        // Exhaustive sweep: scheme x class x core x page nibble; R8 via varied other bits
        k = 0;
        for (int sch = 0; sch < 4; sch++) begin
            for (int sh = 0; sh < 2; sh++) begin
                for (int cd = 0; cd < 2; cd++) begin
                    for (int core = 0; core < 16; core++) begin
                        for (int pg = 0; pg < 16; pg++) begin
                            a = '0;
                            a[11:0]  = 12'((k * 37) & 12'hFFF);
                            a[15:12] = 4'(pg);
                            a[39:16] = 24'(k * 7919);
                            k++;
                            issue(sch, sh, cd, core, a);
                            check(tag_of(sch, sh), int'(home_bank),
                                  model_bank(sch, sh, cd, core, a));
                            check("R2 valid", int'(home_valid), 1);
                        end
                    end
                end
            end
        end

        // R8: same page, different offset and upper bits
        a = 40'h00_0000_3000;
        issue(2, 1, 0, 0, a);
        held = int'(home_bank);
        a = 40'hAB_CDEF_3FFF;
        issue(2, 1, 0, 0, a);
        check("R8 spread", int'(home_bank), held);
        a = 40'h55_5555_2ABC;
        issue(0, 1, 1, 7, a);
        check("R8 central", int'(home_bank), 9);

        // R9: idle cycle with changed inputs holds the bank
        issue(0, 0, 0, 12, 40'h0);
        held = int'(home_bank);
        req_valid  = 1'b0;
        req_core   = 4'd3;
        req_shared = 1'b1;
        scheme_sel = 2'b10;
        req_addr   = 40'h0000_F000;
        @(negedge clk);
        check("R9 hold", int'(home_bank), held);
        check("R2 drop", int'(home_valid), 0);
        @(negedge clk);
        check("R9 hold2", int'(home_bank), 12);

        // R1: reset after activity
        issue(2, 1, 0, 0, 40'h0000_B000);
        rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset valid", int'(home_valid), 0);
        check("R1 re-reset bank", int'(home_bank), 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule